// File: doc/BRIEF.md
# Debug Test Access Port with Indirect Chain Selection

This block is the target-side serial test port of a processor core. A debug probe drives a test clock, a mode-select line, serial data in and an active-low port reset. Through these it steps the standard 16-state controller, loads 4-bit instructions, and shifts data through whichever register the current instruction connects between serial input and serial output.

Besides the usual identification and bypass registers, one instruction connects a 4-bit chain-number register. The number written there is committed when the data scan completes. After that, a separate test instruction routes data scans to the internal chain with that number. In this block two stand-in chains take the place of the real core logic: a 33-bit one, numbered 1, and a 38-bit one, numbered 2. The stand-in chains keep their contents between scans, so data shifted into a chain comes back out on the next scan of that chain.

Top module: `dbg_tap_chainsel`

## Requirements
- R1: The controller follows the 16-state test-port graph, moving on the mode-select value sampled at the rising test-clock edge; five consecutive ones on mode-select bring it to Test-Logic-Reset from any state.
- R2: A low level on trst_n at once puts the controller in Test-Logic-Reset, sets the active instruction to 1110, and drives tdo_oe low, without waiting for a clock edge.
- R3: Serial input is sampled on the rising edge and tdo changes only on the falling edge; tdo_oe is high exactly while the controller is in Shift-IR or Shift-DR.
- R4: In Capture-IR the instruction shift register loads 0001, which leaves on tdo least significant bit first during Shift-IR.
- R5: The active instruction changes only in Update-IR (to the shifted value) or in Test-Logic-Reset (to 1110); a shift abandoned before Update-IR leaves it as it was.
- R6: Instruction 1110 connects a 32-bit identification register that captures the ID_VALUE parameter in Capture-DR and shifts it out least significant bit first.
- R7: Instruction 0010 connects a 4-bit chain-number register. It captures the committed chain number, which is 0 after trst_n, and the shifted value becomes the committed number in Update-DR.
- R8: With instruction 1100 and committed chain number 1, data scans pass through a 33-bit chain that holds its contents across Capture-DR, so each scan returns the 33 bits shifted in by the previous scan of that chain.
- R9: With instruction 1100 and committed chain number 2, data scans pass through a 38-bit chain with the same holding behaviour.
- R10: With instruction 1100 and any other committed chain number, the 1-bit bypass register is connected.
- R11: Instruction 1111 and every code other than 1110, 0010 and 1100 connect the 1-bit bypass register, which captures 0, so a data scan returns a 0 followed by the input delayed by one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data into the selected register |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_oe | output | 1 | High while tdo carries shift data |

## Verification
The hardest state to reach is a long internal chain holding known contents under a committed chain number. Getting there takes an instruction scan, a chain-number data scan, another instruction scan and then two full-length data scans, because the first scan of a chain only loads it. The bench runs this sequence for both chains. It then switches to an unmapped number and back again, which shows that the chain that was left alone kept its bits. An instruction shift abandoned through an asynchronous port reset while in Pause-IR shows that nothing short of Update-IR changes the instruction.

// File: rtl/dbg_tap_pkg.sv
`timescale 1ns/1ps
package dbg_tap_pkg;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_IDCODE     = 4'b1110;
    localparam instr_t OP_SCAN_SEL   = 4'b0010;
    localparam instr_t OP_CHAIN_TEST = 4'b1100;
    localparam instr_t OP_BYPASS     = 4'b1111;
    localparam instr_t IR_CAPTURE    = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDENT, DR_CHSEL, DR_CHAIN
    } dr_path_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
`timescale 1ns/1ps
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= tap_next(state, tms);
    end

    always_comb begin
        in_reset = (state == ST_TLR);
        cap_ir   = (state == ST_CAP_IR);
        shf_ir   = (state == ST_SHF_IR);
        upd_ir   = (state == ST_UPD_IR);
        cap_dr   = (state == ST_CAP_DR);
        shf_dr   = (state == ST_SHF_DR);
        upd_dr   = (state == ST_UPD_DR);
    end

endmodule

// File: rtl/dbg_tap_shreg.sv
`timescale 1ns/1ps
module dbg_tap_shreg #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         cap_en,
    input  logic         shf_en,
    input  logic [W-1:0] cap_val,
    input  logic         tdi,
    output logic         so
);

    logic [W-1:0] q;
    logic [W-1:0] shifted;

    generate
        if (W == 1) begin : g_one
            assign shifted = tdi;
        end else begin : g_wide
            assign shifted = {tdi, q[W-1:1]};
        end
    endgenerate

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     q <= RST_VAL;
        else if (cap_en) q <= cap_val;
        else if (shf_en) q <= shifted;
    end

    assign so = q[0];

endmodule

// File: rtl/dbg_tap_ir.sv
`timescale 1ns/1ps
module dbg_tap_ir
    import dbg_tap_pkg::*;
(
    input  logic   tck,
    input  logic   trst_n,
    input  logic   tdi,
    input  logic   in_reset,
    input  logic   cap_ir,
    input  logic   shf_ir,
    input  logic   upd_ir,
    output instr_t ir_shadow,
    output instr_t ir_act,
    output logic   ir_so
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     ir_shadow <= IR_CAPTURE;
        else if (cap_ir) ir_shadow <= IR_CAPTURE;
        else if (shf_ir) ir_shadow <= {tdi, ir_shadow[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       ir_act <= OP_IDCODE;
        else if (in_reset) ir_act <= OP_IDCODE;
        else if (upd_ir)   ir_act <= ir_shadow;
    end

    assign ir_so = ir_shadow[0];

endmodule

// File: rtl/dbg_tap_dr_bank.sv
`timescale 1ns/1ps
module dbg_tap_dr_bank
    import dbg_tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1234_5A6B,
    parameter int              SEL_W    = 4,
    parameter int              CH1_LEN  = 33,
    parameter int              CH2_LEN  = 38
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  instr_t           ir_act,
    input  logic             cap_dr,
    input  logic             shf_dr,
    input  logic             upd_dr,
    output logic [SEL_W-1:0] chain_act,
    output logic             dr_so
);

    localparam int NCH         = 2;
    localparam int CH_LEN [NCH] = '{CH1_LEN, CH2_LEN};
    localparam int CH_NUM [NCH] = '{1, 2};

    dr_path_e         path;
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   ch_so;
    logic [SEL_W-1:0] chsel_q;
    logic             id_so;
    logic             byp_so;

    always_comb begin
        path = DR_BYPASS;
        hit  = '0;
        case (ir_act)
            OP_IDCODE:   path = DR_IDENT;
            OP_SCAN_SEL: path = DR_CHSEL;
            OP_CHAIN_TEST: begin
                for (int g = 0; g < NCH; g++) begin
                    if (chain_act == SEL_W'(CH_NUM[g])) begin
                        hit[g] = 1'b1;
                        path   = DR_CHAIN;
                    end
                end
            end
            default:     path = DR_BYPASS;
        endcase
    end

    dbg_tap_shreg #(.W(ID_W), .RST_VAL(ID_VALUE)) u_ident (
        .tck     (tck),
        .trst_n  (trst_n),
        .cap_en  (cap_dr && path == DR_IDENT),
        .shf_en  (shf_dr && path == DR_IDENT),
        .cap_val (ID_VALUE),
        .tdi     (tdi),
        .so      (id_so)
    );

    dbg_tap_shreg #(.W(1), .RST_VAL(1'b0)) u_bypass (
        .tck     (tck),
        .trst_n  (trst_n),
        .cap_en  (cap_dr && path == DR_BYPASS),
        .shf_en  (shf_dr && path == DR_BYPASS),
        .cap_val (1'b0),
        .tdi     (tdi),
        .so      (byp_so)
    );

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            chsel_q <= '0;
        end else if (path == DR_CHSEL) begin
            if (cap_dr)      chsel_q <= chain_act;
            else if (shf_dr) chsel_q <= {tdi, chsel_q[SEL_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                         chain_act <= '0;
        else if (upd_dr && path == DR_CHSEL) chain_act <= chsel_q;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chain
        dbg_tap_shreg #(.W(CH_LEN[g]), .RST_VAL('0)) u_chain (
            .tck     (tck),
            .trst_n  (trst_n),
            .cap_en  (1'b0),
            .shf_en  (shf_dr && hit[g]),
            .cap_val ('0),
            .tdi     (tdi),
            .so      (ch_so[g])
        );
    end

    always_comb begin
        case (path)
            DR_IDENT: dr_so = id_so;
            DR_CHSEL: dr_so = chsel_q[0];
            DR_CHAIN: dr_so = |(hit & ch_so);
            default:  dr_so = byp_so;
        endcase
    end

endmodule

// File: rtl/dbg_tap_chainsel.sv
`timescale 1ns/1ps
module dbg_tap_chainsel
    import dbg_tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1234_5A6B,
    parameter int              SEL_W    = 4,
    parameter int              CH1_LEN  = 33,
    parameter int              CH2_LEN  = 38
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe
);

    tap_state_e       st;
    logic             in_reset, cap_ir, shf_ir, upd_ir, cap_dr, shf_dr, upd_dr;
    instr_t           ir_shadow, ir_act;
    logic             ir_so, dr_so;
    logic [SEL_W-1:0] chain_act;

    dbg_tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .state    (st),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .shf_ir   (shf_ir),
        .upd_ir   (upd_ir),
        .cap_dr   (cap_dr),
        .shf_dr   (shf_dr),
        .upd_dr   (upd_dr)
    );

    dbg_tap_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .in_reset  (in_reset),
        .cap_ir    (cap_ir),
        .shf_ir    (shf_ir),
        .upd_ir    (upd_ir),
        .ir_shadow (ir_shadow),
        .ir_act    (ir_act),
        .ir_so     (ir_so)
    );

    dbg_tap_dr_bank #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE),
        .SEL_W    (SEL_W),
        .CH1_LEN  (CH1_LEN),
        .CH2_LEN  (CH2_LEN)
    ) u_dr (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .ir_act    (ir_act),
        .cap_dr    (cap_dr),
        .shf_dr    (shf_dr),
        .upd_dr    (upd_dr),
        .chain_act (chain_act),
        .dr_so     (dr_so)
    );

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shf_ir | shf_dr;
            tdo    <= shf_ir ? ir_so : dr_so;
        end
    end

endmodule

// File: rtl/dbg_tap_chk.sv
`timescale 1ns/1ps
module dbg_tap_chk
    import dbg_tap_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input logic             tdo_oe,
    input tap_state_e       st,
    input instr_t           ir_shadow,
    input instr_t           ir_act,
    input logic [SEL_W-1:0] chain_act
);

    logic [2:0] ones_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)             ones_run <= '0;
        else if (!tms)           ones_run <= '0;
        else if (ones_run != 5)  ones_run <= ones_run + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        ones_run == 3'd5 |-> st == ST_TLR); // R1

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (st == ST_SHF_IR || st == ST_SHF_DR)); // R3

    AST_IR_CAPTURE_CONST: assert property (@(posedge tck) disable iff (!trst_n)
        $past(st) == ST_CAP_IR |-> ir_shadow == 4'b0001); // R4

    AST_IR_UPDATE_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
        ir_act != $past(ir_act) |-> ($past(st) == ST_UPD_IR || $past(st) == ST_TLR)); // R5

    AST_TLR_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
        $past(st) == ST_TLR |-> ir_act == OP_IDCODE); // R5

    AST_CHAIN_UPDATE_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
        chain_act != $past(chain_act) |->
            ($past(st) == ST_UPD_DR && $past(ir_act) == OP_SCAN_SEL)); // R7

endmodule

bind dbg_tap_chainsel dbg_tap_chk #(.SEL_W(SEL_W)) u_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tdo_oe    (tdo_oe),
    .st        (st),
    .ir_shadow (ir_shadow),
    .ir_act    (ir_act),
    .chain_act (chain_act)
);

// File: tb/dbg_tap_chainsel_test.sv
`timescale 1ns/1ps
module dbg_tap_chainsel_test;

    localparam logic [31:0] ID = 32'h1234_5A6B;

    localparam int S_TLR = 0,  S_RTI = 1,  S_SDR = 2,  S_CDR = 3,
                   S_SHD = 4,  S_E1D = 5,  S_PDR = 6,  S_E2D = 7,
                   S_UDR = 8,  S_SIR = 9,  S_CIR = 10, S_SHI = 11,
                   S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_oe;

    int n_checks = 0;
    int n_fail = 0;
    int m_state = S_TLR;
    logic last_tdo = 1'b0;
    logic [63:0] dout;
    logic [63:0] ch1_m = '0;
    logic [63:0] ch2_m = '0;
    logic [3:0]  chain_m = '0;

    always #10 tck = ~tck;

    dbg_tap_chainsel #(.ID_VALUE(ID)) uut (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .tdi    (tdi),
        .tdo    (tdo),
        .tdo_oe (tdo_oe)
    );

    function automatic int ref_next(input int s, input logic m);
        case (s)
            S_TLR: return m ? S_TLR : S_RTI;
            S_RTI: return m ? S_SDR : S_RTI;
            S_SDR: return m ? S_SIR : S_CDR;
            S_CDR, S_SHD: return m ? S_E1D : S_SHD;
            S_E1D: return m ? S_UDR : S_PDR;
            S_PDR: return m ? S_E2D : S_PDR;
            S_E2D: return m ? S_UDR : S_SHD;
            S_SIR: return m ? S_TLR : S_CIR;
            S_CIR, S_SHI: return m ? S_E1I : S_SHI;
            S_E1I: return m ? S_UIR : S_PIR;
            S_PIR: return m ? S_E2I : S_PIR;
            S_E2I: return m ? S_UIR : S_SHI;
            default: return m ? S_SDR : S_RTI;
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one test-clock period: inputs set after a falling edge, tdo sampled after the next falling edge
    task automatic step(input logic t, input logic d);
        tms = t;
        tdi = d;
        @(posedge tck);
        #2;
        chk(tdo === last_tdo, "R3 tdo held at rising edge", 64'(tdo), 64'(last_tdo));
        m_state = ref_next(m_state, t);
        @(negedge tck);
        #2;
        last_tdo = tdo;
        chk(tdo_oe === (m_state == S_SHD || m_state == S_SHI), "R3 tdo_oe vs state",
            64'(tdo_oe), 64'(m_state == S_SHD || m_state == S_SHI));
    endtask

    // starts and ends in Run-Test/Idle
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din, output logic [63:0] got);
        got = '0;
        step(1'b1, 1'b0);
        if (is_ir) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            got[i] = tdo;
            step(i == n - 1, din[i]);
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic scan_chk(input bit is_ir, input int n, input logic [63:0] din,
                            input logic [63:0] exp, input string req);
        logic [63:0] mask;
        mask = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        scan(is_ir, n, din, dout);
        chk((dout & mask) === (exp & mask), req, dout & mask, exp & mask);
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge tck);
        #2;
        trst_n = 1'b1;
        last_tdo = tdo;
        chk(tdo_oe === 1'b0, "R2 tdo_oe low after reset", 64'(tdo_oe), 64'd0);

        step(1'b0, 1'b0);
        scan_chk(1'b0, 32, 64'h0, 64'(ID), "R6 R2 identification after reset");

        scan_chk(1'b1, 4, 64'hF, 64'h1, "R4 capture pattern");
        scan_chk(1'b0, 8, 64'hA5, 64'h4A, "R11 bypass 1111");
        scan_chk(1'b1, 4, 64'h5, 64'h1, "R4 capture pattern again");
        scan_chk(1'b0, 8, 64'h3C, 64'h78, "R11 bypass for unsupported 0101");

        // R5: abandon an instruction shift in Pause-IR through the port reset
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        #3;
        trst_n = 1'b0;
        #1;
        chk(tdo_oe === 1'b0, "R2 tdo_oe low during reset", 64'(tdo_oe), 64'd0);
        repeat (2) @(negedge tck);
        #2;
        trst_n = 1'b1;
        m_state = S_TLR;
        last_tdo = tdo;
        step(1'b0, 1'b0);
        scan_chk(1'b0, 32, 64'h0, 64'(ID), "R5 R2 instruction kept after abandoned shift");

        // R1: five ones from Shift-DR reach Test-Logic-Reset, which reloads 1110
        scan_chk(1'b1, 4, 64'hF, 64'h1, "R4 before R1 sequence");
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk(m_state == S_TLR, "R1 reference reached reset", 64'(m_state), 64'(S_TLR));
        step(1'b0, 1'b0);
        scan_chk(1'b0, 32, 64'h0, 64'(ID), "R1 identification after five ones");

        // chain number 1
        scan_chk(1'b1, 4, 64'h2, 64'h1, "R4 load 0010");
        scan_chk(1'b0, 4, 64'h1, 64'(chain_m), "R7 chain number after reset is 0");
        chain_m = 4'd1;
        scan_chk(1'b1, 4, 64'hC, 64'h1, "R4 load 1100");
        scan_chk(1'b0, 33, 64'h1_2345_6789, ch1_m, "R8 first chain 1 scan");
        ch1_m = 64'h1_2345_6789;
        scan_chk(1'b0, 33, 64'h0_DEAD_BEEF, ch1_m, "R8 chain 1 returns prior data");
        ch1_m = 64'h0_DEAD_BEEF;

        // chain number 2
        scan_chk(1'b1, 4, 64'h2, 64'h1, "R4 load 0010");
        scan_chk(1'b0, 4, 64'h2, 64'(chain_m), "R7 reads committed number 1");
        chain_m = 4'd2;
        scan_chk(1'b1, 4, 64'hC, 64'h1, "R4 load 1100");
        scan_chk(1'b0, 38, 64'h2A_5A5A_0F0F, ch2_m, "R9 first chain 2 scan");
        ch2_m = 64'h2A_5A5A_0F0F;
        scan_chk(1'b0, 38, 64'h15_C3C3_1234, ch2_m, "R9 chain 2 returns prior data");
        ch2_m = 64'h15_C3C3_1234;

        // unmapped chain number 5
        scan_chk(1'b1, 4, 64'h2, 64'h1, "R4 load 0010");
        scan_chk(1'b0, 4, 64'h5, 64'(chain_m), "R7 reads committed number 2");
        chain_m = 4'd5;
        scan_chk(1'b1, 4, 64'hC, 64'h1, "R4 load 1100");
        scan_chk(1'b0, 8, 64'h96, 64'h2C, "R10 unmapped chain uses bypass");

        // back to chain 1: contents survived
        scan_chk(1'b1, 4, 64'h2, 64'h1, "R4 load 0010");
        scan_chk(1'b0, 4, 64'h1, 64'(chain_m), "R7 reads committed number 5");
        chain_m = 4'd1;
        scan_chk(1'b1, 4, 64'hC, 64'h1, "R4 load 1100");
        scan_chk(1'b0, 33, 64'h0, ch1_m, "R8 chain 1 retained across other scans");

        summary();
    end

endmodule